// File: doc/BRIEF.md
# Bit-Addressed Serial Configuration Slave

This block is the slave side of a four-pin serial port on a measurement chip. A host uses it to change single bits of a 128-bit configuration and mode store. It also uses it to read back 32-bit result words that the chip has produced.

The pins are:
- an active-low select;
- a direction line that picks read or write;
- a serial clock;
- a data pin, split here into input, output and output-enable.

**Write mode** (direction line low while selected). Each byte names one bit of the store and the value to put there. The data value comes first, then the 7-bit address, MSB first. The clock pulse that carries the last address bit also stores the bit. For that reason the whole write path runs on the serial clock and power-on reset alone.

**Read mode** (direction line high while selected). The block drives the data pin. It shifts out a set of 32-bit transmission latches, MSB first, one record after another.

Those latches are filled from the result inputs by a strobe. The host makes the strobe by pulsing the direction line low while the select is high. The strobe is brought into the system clock domain through two synchronizer flops.

The store is split at bit 96:
- Bits 0 to 95 are configuration bits.
- Bits 96 to 125 are mode signals. Bit 120 among them sets the serial clock polarity.
- Address 126 is the remote reset command.
- Address 127 is a dead address, so the all-ones byte acts as a precharge that changes nothing.

Top module: `bitcfg_serial_slave`

## Requirements
- R1: After power-on reset every store bit reads 0, the data output is disabled, and a read with no prior strobe shifts out zeros.
- R2: A write byte {value, addr[6:0]}, sent MSB first while select and direction are both low, sets store bit addr to value on the leading clock edge of its eighth bit. For example, byte 0xAF sets bit 47 and 0x2F clears it.
- R3: Several write bytes sent back to back in one select window each take effect, in order.
- R4: Raising the select during a partial byte drops that byte with no store change, and the next window starts a fresh byte.
- R5: The byte 0xFF changes no store bit.
- R6: Writing 1 to address 126 (byte 0xFE) clears bits 0 to 95 and leaves bits 96 to 125 unchanged. Writing 0 there (0x7E) does nothing.
- R7: The data output is enabled exactly while select is low and the direction line is high.
- R8: A low pulse on the direction line while select is high copies all result inputs into the transmission latches. Later changes at the result inputs are not seen until the next such pulse.
- R9: A read shifts out record 0 first, bit 31 first, then records 1 to NREC-1, and wraps back to record 0. The first bit is valid from the select falling edge, and each trailing clock edge advances one bit.
- R10: Store bit 120 sets the clock polarity. At 0 the clock idles high and the falling edge is leading. At 1 the clock idles low and the rising edge is leading. Writes and reads work in both settings.
- R11: Bits 126 and 127 of the store always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the latch strobe domain |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Port select, active low |
| rw_sel | input | 1 | Direction line: 1 read, 0 write; a low pulse while deselected latches results |
| sck | input | 1 | Serial clock |
| sda_in | input | 1 | Serial data from host |
| sda_out | output | 1 | Serial data to host |
| sda_oe | output | 1 | Output enable for the data pin |
| res_in | input | NREC*32 | Result words, record i at bits i*32+31 down to i*32 |
| cfg_bits | output | 128 | Configuration and mode store |

## Verification
Each write is visible at the store output on the same leading edge that carries its last bit. So a bad shift register, a miscounted bit or a wrong address decode shows up as a wrong store bit within one clock of that edge. The reference model compares every bit of the store on every clock.

A wrong read counter or record select corrupts the very next bit on the data pin. A stale or premature latch copy appears in the first word read after a strobe.

Stray output-enable activity is caught on the clock cycle it occurs.

// File: rtl/bitcfg_serial_slave.sv
module bitcfg_serial_slave #(
  parameter int NREC      = 4,
  parameter int ADDR_W    = 7,
  parameter int MODE_BASE = 96,
  parameter int POL_BIT   = 120
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 cs_n,
  input  logic                 rw_sel,
  input  logic                 sck,
  input  logic                 sda_in,
  output logic                 sda_out,
  output logic                 sda_oe,
  input  logic [NREC*32-1:0]   res_in,
  output logic [(1<<ADDR_W)-1:0] cfg_bits
);
  localparam int NBITS = 1 << ADDR_W;
  localparam int RST_A = NBITS - 2;
  localparam int DEAD_A = NBITS - 1;
  localparam int TOTAL = NREC * 32;
  localparam int RW = $clog2(TOTAL);
  localparam logic [NBITS-1:0] CFG_MASK = {{(NBITS-MODE_BASE){1'b0}}, {MODE_BASE{1'b1}}};

  logic [NBITS-1:0]        cfg_q;
  logic [NREC-1:0][31:0]   rec_q;
  logic [ADDR_W-1:0]       wr_sh;
  logic [2:0]              wr_cnt;
  logic [RW-1:0]           rd_cnt;
  logic                    eclk;
  logic                    cmd_val;
  logic [ADDR_W-1:0]       cmd_adr;
  logic                    rw_m, rw_s, rw_p, cs_m, cs_s;
  logic                    lat_stb;

  assign eclk    = sck ~^ cfg_q[POL_BIT];
  assign cmd_val = wr_sh[ADDR_W-1];
  assign cmd_adr = {wr_sh[ADDR_W-2:0], sda_in};
  assign cfg_bits = cfg_q;
  assign sda_oe  = ~cs_n & rw_sel;
  assign sda_out = rec_q[rd_cnt[RW-1:5]][5'd31 - rd_cnt[4:0]];

  always_ff @(posedge eclk or posedge cs_n) begin
    if (cs_n) begin
      wr_cnt <= '0;
      wr_sh  <= '0;
    end else if (!rw_sel) begin
      wr_cnt <= wr_cnt + 3'd1;
      wr_sh  <= {wr_sh[ADDR_W-2:0], sda_in};
    end
  end

  always_ff @(posedge eclk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0;
    end else if (!cs_n && !rw_sel && wr_cnt == 3'd7) begin
      if (int'(cmd_adr) == RST_A) begin
        if (cmd_val) cfg_q <= cfg_q & ~CFG_MASK;
      end else if (int'(cmd_adr) != DEAD_A) begin
        cfg_q[cmd_adr] <= cmd_val;
      end
    end
  end

  always_ff @(negedge eclk or posedge cs_n) begin
    if (cs_n) rd_cnt <= '0;
    else if (rw_sel) rd_cnt <= (rd_cnt == RW'(TOTAL-1)) ? '0 : rd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      {rw_m, rw_s, rw_p} <= 3'b111;
      {cs_m, cs_s}       <= 2'b11;
    end else begin
      {rw_m, rw_s, rw_p} <= {rw_sel, rw_m, rw_s};
      {cs_m, cs_s}       <= {cs_n, cs_m};
    end
  end

  assign lat_stb = rw_p & ~rw_s & cs_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rec_q <= '0;
    else if (lat_stb) begin
      for (int i = 0; i < NREC; i++) rec_q[i] <= res_in[i*32 +: 32];
    end
  end
endmodule

module bitcfg_serial_slave_chk #(
  parameter int NBITS = 128,
  parameter int NREC  = 4
) (
  input logic               clk,
  input logic               por_n,
  input logic               cs_n,
  input logic               rw_sel,
  input logic               sda_oe,
  input logic [NBITS-1:0]   cfg_bits,
  input logic [NREC*32-1:0] rec_q,
  input logic               lat_stb
);
  assert_oe_off_deselected_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cs_n || !rw_sel) |-> !sda_oe);
  assert_top_bits_zero_R11: assert property (@(posedge clk) disable iff (!por_n)
    cfg_bits[NBITS-1 -: 2] == 2'b00);
  assert_store_moves_in_window_R2: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(cfg_bits) |-> (!cs_n || $past(!cs_n)));
  assert_latch_only_on_strobe_R8: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(rec_q) |-> $past(lat_stb));
endmodule

bind bitcfg_serial_slave bitcfg_serial_slave_chk #(.NBITS(NBITS), .NREC(NREC)) u_chk (
  .clk(clk), .por_n(por_n), .cs_n(cs_n), .rw_sel(rw_sel), .sda_oe(sda_oe),
  .cfg_bits(cfg_bits), .rec_q(rec_q), .lat_stb(lat_stb)
);

// File: tb/bitcfg_serial_slave_tb.sv
module bitcfg_serial_slave_tb;
  localparam int NREC = 4;

  logic clk = 0, por_n = 0, cs_n = 1, rw_sel = 1, sck = 1, sda_in = 1;
  logic sda_out, sda_oe;
  logic [NREC*32-1:0] res_in = '0;
  logic [127:0] cfg_bits;

  logic [127:0] m_cfg = '0;
  logic [31:0]  m_rec [NREC];
  logic         pol = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  bitcfg_serial_slave #(.NREC(NREC)) u_dut (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .rw_sel(rw_sel), .sck(sck),
    .sda_in(sda_in), .sda_out(sda_out), .sda_oe(sda_oe), .res_in(res_in),
    .cfg_bits(cfg_bits));

  always #4 clk = ~clk;

  always @(negedge clk) if (por_n && !done) begin
    checks++;
    if (cfg_bits !== m_cfg) begin
      fails++;
      $display("FAIL R2 store: got %h exp %h", cfg_bits, m_cfg);
    end
    checks++;
    if (sda_oe !== (!cs_n && rw_sel)) begin
      fails++;
      $display("FAIL R7 oe: got %b exp %b", sda_oe, (!cs_n && rw_sel));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic void apply(logic [7:0] b);
    if (b == 8'hFF) return;
    if (b[6:0] == 7'd126) begin
      if (b[7]) m_cfg[95:0] = '0;
    end else if (b[6:0] != 7'd127) m_cfg[b[6:0]] = b[7];
  endfunction

  task automatic open_wr();
    cs_n = 0; tick(2); rw_sel = 0; tick(2);
  endtask

  task automatic close_win();
    rw_sel = 1; tick(2); cs_n = 1; tick(2);
  endtask

  task automatic send_bits(logic [7:0] b, int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_in = b[i]; tick(2);
      sck = pol; if (i == 0) apply(b); tick(2);
      sck = ~pol; tick(2);
    end
    sda_in = 1;
  endtask

  task automatic strobe();
    rw_sel = 0; tick(3); rw_sel = 1; tick(6);
    for (int r = 0; r < NREC; r++) m_rec[r] = res_in[r*32 +: 32];
  endtask

  task automatic read_bits(int n, string req);
    cs_n = 0; tick(2);
    for (int k = 0; k < n; k++) begin
      logic e;
      e = m_rec[(k / 32) % NREC][31 - (k % 32)];
      checks++;
      if (sda_out !== e) begin
        fails++;
        $display("FAIL %s read bit %0d: got %b exp %b", req, k, sda_out, e);
      end
      sck = pol; tick(2);
      sck = ~pol; tick(2);
    end
    cs_n = 1; tick(2);
  endtask

  initial begin
    for (int r = 0; r < NREC; r++) m_rec[r] = '0;
    tick(3); por_n = 1; tick(2);
    check("R1 store", cfg_bits, '0);
    check("R1 oe", sda_oe, 0);
    read_bits(40, "R1");

    open_wr(); send_bits(8'hAF, 8); close_win();
    check("R2 set47", cfg_bits[47], 1);
    open_wr(); send_bits(8'h2F, 8); close_win();
    check("R2 clr47", cfg_bits[47], 0);

    open_wr();
    send_bits(8'h83, 8); send_bits(8'hDF, 8); send_bits(8'hE4, 8);
    send_bits(8'hFD, 8); send_bits(8'h03, 8); send_bits(8'h8A, 8);
    close_win();
    check("R3 seq", cfg_bits, m_cfg);
    check("R3 bit3", cfg_bits[3], 0);

    open_wr(); send_bits(8'h90, 4); close_win();
    check("R4 abort", cfg_bits, m_cfg);
    open_wr(); send_bits(8'h90, 8); close_win();
    check("R4 fresh", cfg_bits[16], 1);

    open_wr(); send_bits(8'hFF, 8); send_bits(8'h7E, 8); send_bits(8'h7F, 8); close_win();
    check("R5 noop", cfg_bits, m_cfg);
    check("R11 top", cfg_bits[127:126], 0);

    open_wr(); send_bits(8'hFE, 8); close_win();
    check("R6 low cleared", cfg_bits[95:0], '0);
    check("R6 mode kept", {cfg_bits[125], cfg_bits[100]}, 2'b11);

    for (int r = 0; r < NREC; r++) res_in[r*32 +: 32] = 32'hA5C30F71 ^ (32'h11111111 * (r + 1));
    strobe();
    res_in = ~res_in;
    tick(4);
    read_bits(NREC * 32 + 40, "R9");
    read_bits(32, "R8 stale");
    strobe();
    read_bits(64, "R8 new");

    open_wr(); send_bits(8'hF8, 8); close_win();
    check("R10 pol", cfg_bits[120], 1);
    pol = 1; sck = 0; tick(3);
    open_wr(); send_bits(8'h85, 8); send_bits(8'hD5, 8); close_win();
    check("R10 write", {cfg_bits[85], cfg_bits[5]}, 2'b11);
    read_bits(48, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule